// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Resolver

This block picks which pending interrupt request a processor core services next. Eleven request lines are arranged in six fixed groups. Each group has a two-bit priority level. One bit of that level comes from a low priority register and the other from a high priority register. The resolver compares every pending, enabled request against the levels already in service. It chooses one winner and reports it with a one-cycle vector-request strobe and a source index.

The resolver keeps a four-bit in-service record with one bit per level. A new request is accepted only if its level is strictly above the highest level currently being serviced, so interrupts nest in strict priority order. A return-from-interrupt pulse retires the innermost (highest) active level. A global enable gates every request. Resolution is combinational and the grant is registered, so a request seen in one cycle is reported after the next clock edge.

Source numbering follows the polling order. Source i belongs to group i/2, and the lower index in a group is polled first: 0 ext0, 1 serial1, 2 timer0, 3 ext2, 4 ext1, 5 ext3, 6 timer1, 7 ext4, 8 serial0, 9 ext5, 10 ext6.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, `vec_req` is 0, `vec_src` is 0, `in_service` is 0000, and both priority registers are zero, so every group is at level 0.
- R2: Source i maps to group i/2. The level of group g is {hi[g], lo[g]}, where 00 is level 0 (lowest) and 11 is level 3. A clock edge with `pri_wr_lo` or `pri_wr_hi` high loads `pri_wdata` into the low or high register.
- R3: Among the eligible requests, the one at the highest level wins.
- R4: When several eligible requests share the winning level, the lowest source index wins. This means ascending group order, and within a group the lower index first.
- R5: A request is eligible only if its level is strictly greater than the highest level set in `in_service`. A request at an equal or lower level gets no grant while that level stays active.
- R6: A winner resolved in one cycle produces `vec_req`=1 and `vec_src`=index after the next edge, and sets `in_service[level]`. `vec_src` holds its value while no grant occurs.
- R7: A `reti` pulse clears the highest set bit of `in_service`. When `in_service` is 0000, `reti` has no effect.
- R8: When `reti` and a request fall in the same cycle, the pop is applied first and the request is judged against the reduced in-service state.
- R9: While `irq_en` is low, no grant is made and `in_service` does not change apart from `reti`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Global request enable |
| req | input | 11 | Pending request per source |
| pri_wr_lo | input | 1 | Load `pri_wdata` into low priority register |
| pri_wr_hi | input | 1 | Load `pri_wdata` into high priority register |
| pri_wdata | input | 6 | Priority register write data, one bit per group |
| reti | input | 1 | Return from interrupt, pop innermost level |
| vec_req | output | 1 | One-cycle vector request strobe |
| vec_src | output | 4 | Index of the granted source |
| in_service | output | 4 | In-service level bits |

## Verification
A return from interrupt and a new request can fall in the same cycle. The bench provokes this by granting a level-2 source and then, in a single cycle, raising `reti` together with a level-1 request that the active level would otherwise block. The case is judged by whether that request is granted on the next edge. After it, `in_service` must show only level 1, which proves the pop took effect before the new request was evaluated and the grant was added on top.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_GRP = 6;
  localparam int NUM_SRC = 11;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int SRC_W   = $clog2(NUM_SRC);
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_prio_pkg::*;
#(
  parameter int GRP = NUM_GRP,
  parameter int SRC = NUM_SRC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_lo,
  input  logic                      wr_hi,
  input  logic [GRP-1:0]            wdata,
  output logic [SRC-1:0][LVL_W-1:0] src_lvl
);
  logic [GRP-1:0] lo_q, lo_d;
  logic [GRP-1:0] hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= lo_d;
      if (wr_hi) hi_q <= hi_d;
    end
  end

  // R2: two sources per group, group index = source / 2
  for (genvar s = 0; s < SRC; s++) begin : g_map
    assign src_lvl[s] = {hi_q[s/2], lo_q[s/2]};
  end

  assert_wr_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));
  assert_wr_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (hi_q == $past(wdata)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int SRC = NUM_SRC,
  parameter int LVL = NUM_LVL
) (
  input  logic [SRC-1:0]            req,
  input  logic [SRC-1:0][LVL_W-1:0] src_lvl,
  input  logic [LVL-1:0]            allow,
  output logic                      win_valid,
  output logic [SRC_W-1:0]          win_src,
  output logic [LVL_W-1:0]          win_lvl
);
  // Highest level first; lowest index first within a level (polling order).
  always_comb begin
    win_valid = 1'b0;
    win_src   = '0;
    win_lvl   = '0;
    for (int l = LVL - 1; l >= 0; l--) begin
      for (int s = 0; s < SRC; s++) begin
        if (!win_valid && req[s] && allow[l] && (src_lvl[s] == LVL_W'(l))) begin
          win_valid = 1'b1;
          win_src   = SRC_W'(s);
          win_lvl   = LVL_W'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack
  import irq_prio_pkg::*;
#(
  parameter int LVL = NUM_LVL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reti,
  input  logic             grant,
  input  logic [LVL_W-1:0] grant_lvl,
  output logic [LVL-1:0]   isr_q,
  output logic [LVL-1:0]   allow
);
  logic [LVL-1:0] eff;
  logic [LVL-1:0] isr_d;
  logic           popped;
  logic           above;

  // R7/R8: pop innermost level before eligibility is judged
  always_comb begin
    eff    = isr_q;
    popped = 1'b0;
    if (reti) begin
      for (int l = LVL - 1; l >= 0; l--) begin
        if (!popped && isr_q[l]) begin
          eff[l] = 1'b0;
          popped = 1'b1;
        end
      end
    end
  end

  // R5: a level is allowed only when no bit at or above it is active
  always_comb begin
    allow = '0;
    for (int l = 0; l < LVL; l++) begin
      above = 1'b0;
      for (int k = l; k < LVL; k++) above = above | eff[k];
      allow[l] = ~above;
    end
  end

  always_comb begin
    isr_d = eff;
    if (grant) isr_d[grant_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else if (reti || grant) isr_q <= isr_d;
  end

  assert_keep_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reti |=> ((isr_q & $past(isr_q)) == $past(isr_q)));
  assert_pop_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !grant && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
  assert_set_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> isr_q[$past(grant_lvl)]);
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int GRP = NUM_GRP,
  parameter int SRC = NUM_SRC,
  parameter int LVL = NUM_LVL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_en,
  input  logic [SRC-1:0]   req,
  input  logic             pri_wr_lo,
  input  logic             pri_wr_hi,
  input  logic [GRP-1:0]   pri_wdata,
  input  logic             reti,
  output logic             vec_req,
  output logic [SRC_W-1:0] vec_src,
  output logic [LVL-1:0]   in_service
);
  logic [SRC-1:0][LVL_W-1:0] src_lvl;
  logic [SRC-1:0]            req_m;
  logic [LVL-1:0]            allow;
  logic                      win_valid;
  logic [SRC_W-1:0]          win_src;
  logic [LVL_W-1:0]          win_lvl;
  logic                      vec_req_d;
  logic [SRC_W-1:0]          vec_src_d;

  assign req_m = req & {SRC{irq_en}};

  irq_level_map #(.GRP(GRP), .SRC(SRC)) i_level_map (
    .clk(clk), .rst_n(rst_n), .wr_lo(pri_wr_lo), .wr_hi(pri_wr_hi),
    .wdata(pri_wdata), .src_lvl(src_lvl)
  );

  irq_arbiter #(.SRC(SRC), .LVL(LVL)) i_arbiter (
    .req(req_m), .src_lvl(src_lvl), .allow(allow),
    .win_valid(win_valid), .win_src(win_src), .win_lvl(win_lvl)
  );

  irq_isr_stack #(.LVL(LVL)) i_isr_stack (
    .clk(clk), .rst_n(rst_n), .reti(reti), .grant(win_valid),
    .grant_lvl(win_lvl), .isr_q(in_service), .allow(allow)
  );

  always_comb begin
    vec_req_d = win_valid;
    vec_src_d = vec_src;
    if (win_valid) vec_src_d = win_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_req <= 1'b0;
      vec_src <= '0;
    end else begin
      vec_req <= vec_req_d;
      if (win_valid) vec_src <= vec_src_d;
    end
  end

  assert_win_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> req_m[win_src]);
  assert_win_allowed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> allow[win_lvl]);
  assert_no_grant_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !vec_req);
  assert_src_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> $stable(vec_src));
endmodule

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_en;
  logic [10:0] req;
  logic        pri_wr_lo, pri_wr_hi;
  logic [5:0]  pri_wdata;
  logic        reti;
  logic        vec_req;
  logic [3:0]  vec_src;
  logic [3:0]  in_service;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_resolver i_irq_prio_resolver (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .req(req),
    .pri_wr_lo(pri_wr_lo), .pri_wr_hi(pri_wr_hi), .pri_wdata(pri_wdata),
    .reti(reti), .vec_req(vec_req), .vec_src(vec_src), .in_service(in_service)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic grant_chk(input string tag, input int src, input int isr);
    chk({tag, " vec_req"}, vec_req, 1);
    chk({tag, " vec_src"}, vec_src, src);
    chk({tag, " in_service"}, in_service, isr);
  endtask

  task automatic idle_chk(input string tag, input int isr);
    chk({tag, " vec_req"}, vec_req, 0);
    chk({tag, " in_service"}, in_service, isr);
  endtask

  task automatic write_prio(input logic [5:0] lo, input logic [5:0] hi);
    pri_wr_lo = 1'b1; pri_wdata = lo; step();
    pri_wr_lo = 1'b0; pri_wr_hi = 1'b1; pri_wdata = hi; step();
    pri_wr_hi = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; irq_en = 1'b1; req = '0; reti = 1'b0;
    pri_wr_lo = 1'b0; pri_wr_hi = 1'b0; pri_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 vec_req", vec_req, 0);
    chk("R1 vec_src", vec_src, 0);
    chk("R1 in_service", in_service, 0);
  endtask

  // all groups level 0 after reset: pure polling order
  task automatic t_poll();
    req = 11'b110_0000_0110;           // sources 1,2,9,10
    step(); grant_chk("R4 R1 poll", 1, 4'b0001);
    step(); idle_chk("R5 equal level held", 4'b0001);
    req = '0; reti = 1'b1;
    step(); idle_chk("R7 pop", 0);
    reti = 1'b0;
  endtask

  task automatic t_levels();
    write_prio(6'b000100, 6'b100000);  // g2 level1, g5 level2
    req = 11'b100_0001_0001;           // sources 0,4,10
    step(); grant_chk("R3 R2 highest level", 10, 4'b0100);
    req = 11'b000_0001_0000;           // source 4, level 1
    step(); idle_chk("R5 lower blocked", 4'b0100);
    write_prio(6'b001100, 6'b101000);  // g3 now level3
    idle_chk("R5 still blocked", 4'b0100);
    req = 11'b000_1001_0000;           // sources 4,7
    step(); grant_chk("R5 preempt", 7, 4'b1100);
    req = '0; reti = 1'b1;
    step(); idle_chk("R7 pop top", 4'b0100);
    step(); idle_chk("R7 pop next", 0);
    step(); idle_chk("R7 empty no effect", 0);
    reti = 1'b0;
  endtask

  task automatic t_group_tie();
    req = 11'b000_1100_0000;           // sources 6,7 same group
    step(); grant_chk("R4 in-group order", 6, 4'b1000);
    req = '0; reti = 1'b1; step(); reti = 1'b0;
    idle_chk("R7 cleanup", 0);
  endtask

  task automatic t_enable();
    irq_en = 1'b0; req = 11'h7FF;
    step(); idle_chk("R9 disabled", 0);
    step(); idle_chk("R9 disabled again", 0);
    chk("R6 vec_src holds", vec_src, 6);
    irq_en = 1'b1;
    step(); grant_chk("R9 R3 enabled", 6, 4'b1000);
    req = '0; reti = 1'b1; step(); reti = 1'b0;
  endtask

  task automatic t_simul();
    req = 11'b100_0000_0000;           // source 10, level 2
    step(); grant_chk("R8 setup", 10, 4'b0100);
    req = 11'b000_0001_0000; reti = 1'b1; // source 4, level 1, with pop
    step(); grant_chk("R8 pop then grant", 4, 4'b0010);
    req = '0; step(); idle_chk("R8 after", 0);
    reti = 1'b0;
  endtask

  initial begin
    t_reset();
    t_poll();
    t_levels();
    t_group_tie();
    t_enable();
    t_simul();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule